// File: doc/BRIEF.md
# Parallel-Prefix Tree Adder

This block adds two WIDTH-bit operands and a carry-in. It forms a single-bit generate and propagate pair for every bit position. A logarithmic network of group generate/propagate merge cells then turns those pairs into the carry entering each bit. The carry-in is merged into the bit 0 generate, so it acts as a generate at position -1. Every prefix the network delivers therefore spans down to and includes the carry-in.

A parameter picks the network shape, and all three shapes produce the same numeric result:
- **TOPO = 0 (sparse):** an up-sweep and down-sweep tree. It has the fewest cells and needs 2·log2(WIDTH)-1 levels.
- **TOPO = 1 (high fanout):** a divide-and-conquer tree. It needs log2(WIDTH) levels and about half of WIDTH·log2(WIDTH) cells, and one node fans out to as many as WIDTH/2+1 cells.
- **TOPO = 2 (fanout 2):** a full-span tree. It needs log2(WIDTH) levels and about WIDTH·log2(WIDTH) cells, keeps fanout at 2, and runs up to WIDTH/2 wires between levels.

The adder core is purely combinational. The sum and carry-out are captured in output registers that a synchronous active-high reset clears. Results therefore appear one clock after the operands are presented. WIDTH must be a power of two and at least 2.

Top module: `prefix_tree_adder`

## Requirements
- R1: One clock edge after a_i, b_i and cin_i are sampled, sum_o equals (a_i + b_i + cin_i) mod 2^WIDTH.
- R2: cout_o, registered on the same edge as sum_o, equals bit WIDTH of the full sum a_i + b_i + cin_i.
- R3: While rst is high at a clock edge, sum_o and cout_o are cleared to zero at that edge.
- R4: When a_i XOR b_i is all ones, the carry-in travels the full width: cout_o equals cin_i, and sum_o is all ones for cin_i = 0 and all zeros for cin_i = 1.
- R5: With TOPO = 0 (sparse network), results satisfy R1 and R2.
- R6: With TOPO = 1 (high-fanout network), results satisfy R1 and R2 and are identical to those of TOPO = 0 for the same operands.
- R7: With TOPO = 2 (fanout-2 network), results satisfy R1 and R2 and are identical to those of TOPO = 0 for the same operands.
- R8: A generate at bit 0 reaches the carry-out. All-ones plus all-ones with carry-in 1 gives sum all ones and carry-out 1.
- R9: The carry-in is merged as a generate below bit 0, so 0 + 0 + 1 gives sum 1 and carry-out 0. Every group propagate delivered by the network is 0, because every span closes on that position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs register on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Registered sum |
| cout_o | output | 1 | Registered carry-out |

## Verification
Every result of this block (sum, carry-out and the reset clear) is due exactly one rising edge after its inputs are present.

The bench sets operands just after a falling edge and lets one rising edge pass. It reads the outputs at the next falling edge, so every read falls half a period from any edge.

One instance of each topology is driven with the same operands in that same window. This lets the three networks be compared against each other and against arithmetic computed in the bench. The in-design properties use a one-cycle $past on the inputs, which matches that single register stage.

// File: rtl/prefix_adder_pkg.sv
package prefix_adder_pkg;

  typedef enum int {
    TREE_SPARSE      = 0,
    TREE_WIDE_FANOUT = 1,
    TREE_DENSE       = 2
  } topo_e;

  // Number of merge levels for a given topology and width
  function automatic int tree_levels(int topo, int width);
    int lg;
    lg = $clog2(width);
    return (topo == TREE_SPARSE) ? (2 * lg - 1) : lg;
  endfunction

endpackage

// File: rtl/pa_bit_pg.sv
module pa_bit_pg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] gen_o,   // generate, carry-in merged at bit 0
  output logic [WIDTH-1:0] prop_o,  // group propagate, bit 0 closed on carry-in
  output logic [WIDTH-1:0] half_o   // raw a^b for the sum stage
);

  logic [WIDTH-1:0] g_raw;

  assign g_raw  = a_i & b_i;
  assign half_o = a_i ^ b_i;

  // carry-in acts as generate at position -1 with propagate 0
  assign gen_o  = {g_raw[WIDTH-1:1], g_raw[0] | (half_o[0] & cin_i)};
  assign prop_o = {half_o[WIDTH-1:1], 1'b0};

endmodule

// File: rtl/pa_prefix_net.sv
module pa_prefix_net
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int TOPO  = 0
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:0] prop_i,
  output logic [WIDTH-1:0] span_g_o,  // G(i:-1)
  output logic [WIDTH-1:0] span_p_o   // P(i:-1), zero when complete
);

  localparam int LG   = $clog2(WIDTH);
  localparam int NLEV = tree_levels(TOPO, WIDTH);

  logic [WIDTH-1:0] gl [NLEV+1];
  logic [WIDTH-1:0] pl [NLEV+1];

  assign gl[0] = gen_i;
  assign pl[0] = prop_i;

  genvar lv, i;
  generate
    if (TOPO == TREE_DENSE) begin : g_dense
      for (lv = 0; lv < LG; lv++) begin : g_lvl
        for (i = 0; i < WIDTH; i++) begin : g_node
          if (i >= (1 << lv)) begin : g_cell
            localparam int J = i - (1 << lv);
            assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][J]);
            assign pl[lv+1][i] = pl[lv][i] & pl[lv][J];
          end else begin : g_wire
            assign gl[lv+1][i] = gl[lv][i];
            assign pl[lv+1][i] = pl[lv][i];
          end
        end
      end
    end else if (TOPO == TREE_WIDE_FANOUT) begin : g_wide
      for (lv = 0; lv < LG; lv++) begin : g_lvl
        for (i = 0; i < WIDTH; i++) begin : g_node
          if (((i >> lv) & 1) == 1) begin : g_cell
            localparam int J = ((i >> lv) << lv) - 1;
            assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][J]);
            assign pl[lv+1][i] = pl[lv][i] & pl[lv][J];
          end else begin : g_wire
            assign gl[lv+1][i] = gl[lv][i];
            assign pl[lv+1][i] = pl[lv][i];
          end
        end
      end
    end else begin : g_sparse
      // up-sweep
      for (lv = 0; lv < LG; lv++) begin : g_up
        for (i = 0; i < WIDTH; i++) begin : g_node
          if (((i + 1) % (1 << (lv + 1))) == 0) begin : g_cell
            localparam int J = i - (1 << lv);
            assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][J]);
            assign pl[lv+1][i] = pl[lv][i] & pl[lv][J];
          end else begin : g_wire
            assign gl[lv+1][i] = gl[lv][i];
            assign pl[lv+1][i] = pl[lv][i];
          end
        end
      end
      // down-sweep
      for (lv = 0; lv < LG - 1; lv++) begin : g_dn
        localparam int L  = LG - 2 - lv;
        localparam int ST = LG + lv;
        for (i = 0; i < WIDTH; i++) begin : g_node
          if ((i >= (1 << (L + 1))) && (((i + 1) % (1 << (L + 1))) == (1 << L))) begin : g_cell
            localparam int J = i - (1 << L);
            assign gl[ST+1][i] = gl[ST][i] | (pl[ST][i] & gl[ST][J]);
            assign pl[ST+1][i] = pl[ST][i] & pl[ST][J];
          end else begin : g_wire
            assign gl[ST+1][i] = gl[ST][i];
            assign pl[ST+1][i] = pl[ST][i];
          end
        end
      end
    end
  endgenerate

  assign span_g_o = gl[NLEV];
  assign span_p_o = pl[NLEV];

endmodule

// File: rtl/pa_sum_stage.sv
module pa_sum_stage #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] half_i,
  input  logic [WIDTH-1:0] span_g_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  // carry into bit i is G(i-1:-1); into bit 0 it is the carry-in
  assign sum_o  = half_i ^ {span_g_i[WIDTH-2:0], cin_i};
  assign cout_o = span_g_i[WIDTH-1];

endmodule

// File: rtl/prefix_tree_adder.sv
module prefix_tree_adder
  import prefix_adder_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int TOPO  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH-1:0] gen, prop, half;
  logic [WIDTH-1:0] span_g, span_p;
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;

  pa_bit_pg #(.WIDTH(WIDTH)) u_pg (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .gen_o(gen), .prop_o(prop), .half_o(half)
  );

  pa_prefix_net #(.WIDTH(WIDTH), .TOPO(TOPO)) u_net (
    .gen_i(gen), .prop_i(prop),
    .span_g_o(span_g), .span_p_o(span_p)
  );

  pa_sum_stage #(.WIDTH(WIDTH)) u_sum (
    .half_i(half), .span_g_i(span_g), .cin_i(cin_i),
    .sum_o(sum_c), .cout_o(cout_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      sum_o  <= sum_c;
      cout_o <= cout_c;
    end
  end

  // R1 R5 R6 R7
  sum_value_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ({cout_o, sum_o} ==
              ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{WIDTH{1'b0}}, $past(cin_i)})));

  // R2
  carry_out_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cout_o == (($past(a_i[WIDTH-1]) & $past(b_i[WIDTH-1])) |
                         (($past(a_i[WIDTH-1]) ^ $past(b_i[WIDTH-1])) & ~sum_o[WIDTH-1]))));

  // R3
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (sum_o == '0 && !cout_o));

  // R4
  full_propagate_chk: assert property (@(posedge clk) disable iff (rst)
    ((a_i ^ b_i) == {WIDTH{1'b1}}) |=>
      (cout_o == $past(cin_i) && sum_o == {WIDTH{~$past(cin_i)}}));

  // R9
  spans_closed_chk: assert property (@(posedge clk) disable iff (rst)
    span_p == '0);

endmodule

// File: tb/sim_prefix_tree_adder.sv
`timescale 1ns/1ps
module sim_prefix_tree_adder;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] s0, s1, s2;
  logic         c0, c1, c2;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  prefix_tree_adder #(.WIDTH(W), .TOPO(0)) u0 (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s0), .cout_o(c0));
  prefix_tree_adder #(.WIDTH(W), .TOPO(1)) u1 (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s1), .cout_o(c1));
  prefix_tree_adder #(.WIDTH(W), .TOPO(2)) u2 (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .cin_i(cin), .sum_o(s2), .cout_o(c2));

  // {a, b, cin, expected cout, expected sum}
  localparam logic [2*W+1+1+W-1:0] VEC [10] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0001},
    {16'hFFFF, 16'h0001, 1'b0, 1'b1, 16'h0000},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF},
    {16'h1234, 16'h4321, 1'b0, 1'b0, 16'h5555},
    {16'h8000, 16'h8000, 1'b0, 1'b1, 16'h0000},
    {16'hAAAA, 16'h5555, 1'b1, 1'b1, 16'h0000},
    {16'hAAAA, 16'h5555, 1'b0, 1'b0, 16'hFFFF},
    {16'h7FFF, 16'h0001, 1'b0, 1'b0, 16'h8000},
    {16'h00FF, 16'h0F01, 1'b1, 1'b0, 16'h1001}
  };

  task automatic chk(input string req, input logic [W:0] got, input logic [W:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc);
    @(negedge clk);
    a = ta; b = tb; cin = tc;
    @(negedge clk);
  endtask

  task automatic check_all(input string tag, input logic [W:0] exp);
    chk({tag, " R5 sparse"}, {c0, s0}, exp);
    chk({tag, " R6 wide"},   {c1, s1}, exp);
    chk({tag, " R7 dense"},  {c2, s2}, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R3: reset state
    check_all("R3 reset", '0);
    rst = 1'b0;

    for (int k = 0; k < 10; k++) begin
      apply(VEC[k][2*W+1+W:W+2+W], VEC[k][W+1+W:W+2], VEC[k][W+1]);
      chk("R1 table sum", {1'b0, s0}, {1'b0, VEC[k][W-1:0]});
      chk("R2 table cout", {{W{1'b0}}, c0}, {{W{1'b0}}, VEC[k][W]});
      check_all("table", VEC[k][W:0]);
    end

    // R4 full-width propagate, both carry-in values
    apply(16'hF0F0, 16'h0F0F, 1'b1);
    check_all("R4 cin=1", {1'b1, 16'h0000});
    apply(16'h0000, 16'hFFFF, 1'b0);
    check_all("R4 cin=0", {1'b0, 16'hFFFF});

    // R8 generate at bit 0 reaching carry-out
    apply(16'h0001, 16'hFFFF, 1'b0);
    check_all("R8 bit0 gen", {1'b1, 16'h0000});
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    check_all("R8 max", {1'b1, 16'hFFFF});

    // R9 carry-in as generate below bit 0
    apply(16'h0000, 16'h0000, 1'b1);
    check_all("R9 cin only", {1'b0, 16'h0001});
    apply(16'h7FFF, 16'h8000, 1'b1);
    check_all("R9 cin ripple", {1'b1, 16'h0000});

    // random sweep with cross-topology comparison
    for (int k = 0; k < 300; k++) begin
      logic [W-1:0] ra, rb;
      logic         rc;
      logic [W:0]   ex;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      ex = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
      apply(ra, rb, rc);
      chk("R1 random", {c0, s0}, ex);
      chk("R6 match sparse", {c1, s1}, {c0, s0});
      chk("R7 match sparse", {c2, s2}, {c0, s0});
    end

    // R3: reset mid-run with live operands
    @(negedge clk);
    a = 16'hFFFF; b = 16'h0001; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    check_all("R3 mid reset", '0);
    rst = 1'b0;
    @(negedge clk);
    check_all("R3 release", {1'b1, 16'h0001});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule